// File: doc/BRIEF.md
# Power-of-Two Serial Clock Prescaler

This block derives the serial clock of an SPI engine from its parent clock. It divides the parent clock by a power of two between 1 and 1024. The ratio is selected by a 16-bit scale code. The transmit side and the receive side each have their own code input. The host normally writes the same value to both. The host picks the code from its target frequency: it takes the smallest ratio that reaches the requested division, and uses 1024 when no ratio is large enough. That selection happens outside this block.

Each code is decoded into two stages. The first is an optional fixed divide-by-32 prescaler. The second is a binary half-period divider, selected by a small exponent field. One dedicated code bypasses both stages and passes the parent clock through. Because of that bypass code, codes are not numbered in ratio order.

The output clock rests at a programmable idle level. Two single-cycle strobes mark where the engine should shift out and where it should sample in. Deasserting the clock enable parks the clock at idle and clears the dividers. The host changes codes only while the enable is low.

Top module: `sckPrescaler`

## Requirements
- R1: Code 0x0007 is the bypass. While enabled, `sck` equals the parent clock XOR `cpol`, and when both codes are 0x0007, `shiftStb` and `sampleStb` are both high in every enabled cycle.
- R2: Code 0x00NN, where NN is 0 to 4, divides by 2^(NN+1). This gives a half period of 2^NN parent cycles (1, 2, 4, 8, 16).
- R3: Code 0x1FNN, where NN is 0 to 4, adds the fixed /32 stage. This divides by 64 to 1024, with a half period of 32·2^NN parent cycles.
- R4: Every code not listed in R1 to R3 behaves as divide-by-1024 (half period 512).
- R5: While `clkEn` is low, `sck` rests at `cpol` and both strobes are low. This also holds in a cycle where an edge would otherwise have been due; the edge is then dropped.
- R6: Counting the cycle in which `clkEn` is first seen high as cycle 0, the first `sck` edge takes effect at the clock edge ending cycle H-1, where H is the half period. After that, `sck` keeps a 50% duty cycle with H cycles high and H cycles low.
- R7: A strobe is one parent cycle wide and sits in the cycle just before the `sck` edge it belongs to. With `cpha`=0, sampling is on the leading edge (away from idle) and shifting on the trailing edge. With `cpha`=1 the two are swapped.
- R8: `sck` and `shiftStb` follow `txScale`. `sampleStb` follows `rxScale`, through a divider of its own.
- R9: While `rstN` is low, `sck` equals `cpol` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Serial clock run enable |
| cpol | input | 1 | Idle level of `sck` |
| cpha | input | 1 | Strobe-to-edge assignment |
| txScale | input | 16 | Transmit scale code |
| rxScale | input | 16 | Receive scale code |
| sck | output | 1 | Serial clock |
| shiftStb | output | 1 | One-cycle strobe before a shift edge |
| sampleStb | output | 1 | One-cycle strobe before a sample edge |

## Verification
Two events can land on the same parent cycle: an edge that the divider has scheduled, and the falling of `clkEn`. The bench runs the divide-by-8 code and drops the enable exactly in the cycle where the sample strobe is due. It then requires that no strobe appears and that `sck` does not leave idle. After re-enabling, it requires the first edge to come a full half period later. A second overlap is the pair of strobes in bypass. There, sample and shift fire together in every cycle, and both are read at the same instant as the passed-through clock level.

// File: rtl/sckDivPkg.sv
package sckDivPkg;
  localparam int NUM_CH = 2;
  localparam int TX_CH = 0;
  localparam int RX_CH = 1;

  typedef struct packed {
    logic bypass;
    logic edgeDue;
  } sckCtlT;
endpackage

// File: rtl/sckDivCtrl.sv
module sckDivCtrl
  import sckDivPkg::*;
#(
  parameter int CODE_W = 16,
  parameter int PRE_LOG = 5,
  parameter int EXP_MAX = 4,
  parameter logic [15:0] BYPASS_CODE = 16'h0007,
  parameter logic [7:0] PRE_TAG = 8'h1F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [CODE_W-1:0] scale,
  output sckCtlT            ctl
);
  localparam int BIN_W = EXP_MAX;
  localparam int EXP_W = $clog2(EXP_MAX + 1);

  logic [7:0]        lowField;
  logic [CODE_W-9:0] highField;
  logic              bypass;
  logic              usePre;
  logic [EXP_W-1:0]  expSel;
  logic [PRE_LOG-1:0] preCnt;
  logic [BIN_W-1:0]  binCnt;
  logic [BIN_W:0]    termVal;
  logic              preWrap;
  logic              binLast;

  assign lowField  = scale[7:0];
  assign highField = scale[CODE_W-1:8];

  // Code decode: bypass, plain exponent, prescaled exponent, else slowest.
  always_comb begin
    bypass = 1'b0;
    usePre = 1'b1;
    expSel = EXP_W'(EXP_MAX);
    if (scale == CODE_W'(BYPASS_CODE)) begin
      bypass = 1'b1;
      usePre = 1'b0;
      expSel = '0;
    end else if (lowField <= 8'(EXP_MAX)) begin
      if (highField == '0) begin
        usePre = 1'b0;
        expSel = lowField[EXP_W-1:0];
      end else if (highField == (CODE_W-8)'(PRE_TAG)) begin
        usePre = 1'b1;
        expSel = lowField[EXP_W-1:0];
      end
    end
  end

  assign termVal = ((BIN_W+1)'(1) << expSel) - (BIN_W+1)'(1);
  assign preWrap = !usePre || (&preCnt);
  assign binLast = ({1'b0, binCnt} >= termVal);

  always_ff @(posedge clk) begin
    if (!rstN || !runEn || bypass) begin
      preCnt <= '0;
      binCnt <= '0;
    end else begin
      preCnt <= usePre ? preCnt + PRE_LOG'(1) : '0;
      if (preWrap) binCnt <= binLast ? '0 : binCnt + BIN_W'(1);
    end
  end

  assign ctl.bypass  = bypass;
  assign ctl.edgeDue = runEn && !bypass && preWrap && binLast;
endmodule

// File: rtl/sckDivPath.sv
module sckDivPath
  import sckDivPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                cpol,
  input  logic                cpha,
  input  sckCtlT [NUM_CH-1:0] ctl,
  output logic                sck,
  output logic                shiftStb,
  output logic                sampleStb
);
  logic [NUM_CH-1:0] phase;
  logic [NUM_CH-1:0] leadStb;
  logic [NUM_CH-1:0] trailStb;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN || !runEn) phase[ch] <= 1'b0;
      else if (ctl[ch].edgeDue) phase[ch] <= ~phase[ch];
    end
    assign leadStb[ch]  = ctl[ch].bypass ? runEn : (ctl[ch].edgeDue && !phase[ch]);
    assign trailStb[ch] = ctl[ch].bypass ? runEn : (ctl[ch].edgeDue && phase[ch]);
  end

  assign shiftStb  = cpha ? leadStb[TX_CH] : trailStb[TX_CH];
  assign sampleStb = cpha ? trailStb[RX_CH] : leadStb[RX_CH];
  assign sck = (ctl[TX_CH].bypass && runEn) ? (clk ^ cpol) : (phase[TX_CH] ^ cpol);
endmodule

// File: rtl/sckPrescaler.sv
module sckPrescaler
  import sckDivPkg::*;
#(
  parameter int CODE_W = 16,
  parameter int PRE_LOG = 5,
  parameter int EXP_MAX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [CODE_W-1:0] txScale,
  input  logic [CODE_W-1:0] rxScale,
  output logic              sck,
  output logic              shiftStb,
  output logic              sampleStb
);
  logic                runEn;
  sckCtlT [NUM_CH-1:0] ctl;

  assign runEn = clkEn && rstN;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ctrl
    sckDivCtrl #(
      .CODE_W (CODE_W),
      .PRE_LOG(PRE_LOG),
      .EXP_MAX(EXP_MAX)
    ) u_ctrl (
      .clk  (clk),
      .rstN (rstN),
      .runEn(runEn),
      .scale((ch == TX_CH) ? txScale : rxScale),
      .ctl  (ctl[ch])
    );
  end

  sckDivPath u_path (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .cpol     (cpol),
    .cpha     (cpha),
    .ctl      (ctl),
    .sck      (sck),
    .shiftStb (shiftStb),
    .sampleStb(sampleStb)
  );
endmodule

// File: rtl/sckPrescalerChk.sv
module sckPrescalerChk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              cpol,
  input logic              cpha,
  input logic [CODE_W-1:0] txScale,
  input logic [CODE_W-1:0] rxScale,
  input logic              sck,
  input logic              shiftStb,
  input logic              sampleStb
);
  localparam logic [CODE_W-1:0] BYP = CODE_W'(16'h0007);

  // R5: disabled for two cycles means sck sits at idle
  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && $past(!clkEn)) |-> (sck == cpol));

  // R5: no strobe while disabled
  p_no_strobe_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> (!shiftStb && !sampleStb));

  // R1: bypass fires both strobes every enabled cycle
  p_bypass_strobes_r1: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && txScale == BYP && rxScale == BYP) |-> (shiftStb && sampleStb));

  // R7: a divided sck edge is always announced by a strobe in the prior cycle
  p_edge_after_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && $past(clkEn) && $stable(cpol) && $stable(txScale) && $stable(rxScale)
     && txScale == rxScale && txScale != BYP && sck != $past(sck))
    |-> $past(shiftStb || sampleStb));

  // R7: with equal divided codes, shift and sample never coincide
  p_strobe_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && txScale == rxScale && txScale != BYP) |-> !(shiftStb && sampleStb));

  // R9: reset holds idle level
  always_comb begin
    if (!rstN) a_reset_idle_r9: assert (sck == cpol || $isunknown(cpol));
  end
endmodule

bind sckPrescaler sckPrescalerChk #(.CODE_W(CODE_W)) chk (.*);

// File: tb/sckPrescaler_test.sv
module sckPrescaler_test;
  localparam int CLK_PERIOD = 10;
  // {code[31:16], cpol[15], cpha[14], half[13:0]}
  localparam int NVEC = 11;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0000, 1'b0, 1'b0, 14'd1},
    {16'h0001, 1'b0, 1'b1, 14'd2},
    {16'h0002, 1'b1, 1'b0, 14'd4},
    {16'h0003, 1'b0, 1'b1, 14'd8},
    {16'h0004, 1'b1, 1'b1, 14'd16},
    {16'h1F00, 1'b0, 1'b0, 14'd32},
    {16'h1F01, 1'b1, 1'b1, 14'd64},
    {16'h1F04, 1'b0, 1'b0, 14'd512},
    {16'h0005, 1'b0, 1'b1, 14'd512},
    {16'h1E00, 1'b1, 1'b0, 14'd512},
    {16'h1F05, 1'b0, 1'b0, 14'd512}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b0;
  logic cpol = 1'b0;
  logic cpha = 1'b0;
  logic [15:0] txScale = 16'h0000;
  logic [15:0] rxScale = 16'h0000;
  logic sck, shiftStb, sampleStb;
  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sckPrescaler uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .cpol(cpol), .cpha(cpha),
    .txScale(txScale), .rxScale(rxScale),
    .sck(sck), .shiftStb(shiftStb), .sampleStb(sampleStb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called right after clkEn was raised (cycle 0, clock low).
  task automatic runWave(input int hTx, input int hRx, input int cycles,
                         input string req);
    int sckBad = 0;
    int stbBad = 0;
    logic [31:0] sckAct = 0, sckExp = 0, stbAct = 0, stbExp = 0;
    for (int k = 0; k < cycles; k++) begin
      logic expSck, txLead, txTrail, rxLead, rxTrail, expShift, expSample;
      expSck  = (((k / hTx) % 2) == 1) ? ~cpol : cpol;
      txLead  = (k % (2*hTx)) == hTx - 1;
      txTrail = (k % (2*hTx)) == 2*hTx - 1;
      rxLead  = (k % (2*hRx)) == hRx - 1;
      rxTrail = (k % (2*hRx)) == 2*hRx - 1;
      expShift  = cpha ? txLead : txTrail;
      expSample = cpha ? rxTrail : rxLead;
      if (sck !== expSck) begin
        if (sckBad == 0) begin sckAct = {k[30:0], sck}; sckExp = {k[30:0], expSck}; end
        sckBad++;
      end
      if (shiftStb !== expShift || sampleStb !== expSample) begin
        if (stbBad == 0) begin
          stbAct = {k[29:0], shiftStb, sampleStb};
          stbExp = {k[29:0], expShift, expSample};
        end
        stbBad++;
      end
      @(negedge clk); #1;
    end
    check(sckBad == 0, req, "sck waveform {cycle,level}", sckAct, sckExp);
    check(stbBad == 0, req, "strobes {cycle,shift,sample} R7", stbAct, stbExp);
  endtask

  task automatic setup(input logic [15:0] tx, input logic [15:0] rx,
                       input logic pol, input logic pha);
    @(negedge clk);
    clkEn = 1'b0; txScale = tx; rxScale = rx; cpol = pol; cpha = pha;
    @(negedge clk);
    clkEn = 1'b1;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R9: reset with enable high and a fast code
    clkEn = 1'b1; cpol = 1'b1; txScale = 16'h0000; rxScale = 16'h0000;
    repeat (3) @(negedge clk);
    #1;
    check(sck === 1'b1, "R9", "sck in reset", {31'd0, sck}, 32'd1);
    check({shiftStb, sampleStb} === 2'b00, "R9", "strobes in reset",
          {30'd0, shiftStb, sampleStb}, 32'd0);
    clkEn = 1'b0;
    @(negedge clk); rstN = 1'b1;

    // R2 R3 R4 R6 R7: table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] code;
      int h;
      string req;
      code = VEC[i][31:16];
      h = int'(VEC[i][13:0]);
      req = (i < 5) ? "R2/R6" : ((i < 8) ? "R3/R6" : "R4/R6");
      setup(code, code, VEC[i][15], VEC[i][14]);
      runWave(h, h, 3*h, req);
    end

    // R8: separate transmit and receive codes
    setup(16'h0000, 16'h0001, 1'b0, 1'b0);
    runWave(1, 2, 12, "R8");
    setup(16'h0002, 16'h0000, 1'b1, 1'b1);
    runWave(4, 1, 16, "R8");

    // R1: bypass, both polarities
    for (int p = 0; p < 2; p++) begin
      setup(16'h0007, 16'h0007, p[0], 1'b0);
      @(negedge clk); #1;
      check(sck === p[0], "R1", "bypass sck while clk low", {31'd0, sck}, {31'd0, p[0]});
      check({shiftStb, sampleStb} === 2'b11, "R1", "bypass strobes",
            {30'd0, shiftStb, sampleStb}, 32'd3);
      @(posedge clk); #1;
      check(sck === ~p[0], "R1", "bypass sck while clk high", {31'd0, sck}, {31'd0, ~p[0]});
    end

    // R5: enable drops in the cycle a sample strobe is due (div 8, cpha 0)
    setup(16'h0002, 16'h0002, 1'b0, 1'b0);
    repeat (3) begin @(negedge clk); #1; end
    clkEn = 1'b0; #1;
    check({shiftStb, sampleStb} === 2'b00, "R5", "strobes when enable drops at edge",
          {30'd0, shiftStb, sampleStb}, 32'd0);
    @(negedge clk); #1;
    check(sck === 1'b0, "R5", "sck stays idle after dropped edge", {31'd0, sck}, 32'd0);
    @(negedge clk); #1;
    check(sck === 1'b0, "R5", "sck idle while disabled", {31'd0, sck}, 32'd0);
    // R6: re-enable restarts a full half period
    clkEn = 1'b1; #1;
    runWave(4, 4, 12, "R6");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule